// File: doc/BRIEF.md
# Binary-Weighted Programmable Delay Line

This block delays a single-bit sampled signal by a programmable whole number of clock cycles. The delay path is a series of binary-weighted sections. Section k is a shift register of 2^k flops, and a multiplexer either inserts that section into the path or bypasses it. A 10-bit select word therefore sets the programmable delay in single-cycle steps. One additional single-flop section exists only to reach a maximum setting that is one step past the all-ones word. A fixed pipeline of `MIN_LAT` flops always follows the sections, so the smallest possible delay is `MIN_LAT` cycles.

The select word and a separate chaining bit pass through a load/hold stage. While `hold_sel` is low the stage is transparent, so new select values act at once. While it is high the stage keeps its contents and ignores further changes on the select and chaining inputs. Two override inputs force the minimum or the maximum delay, and the minimum override wins when both are high. The overrides also clear or fill the stored contents. The chaining bit drives a complementary output pair, which can place a second unit at its minimum or maximum setting so that two units can be chained. An output-enable input forces the output low.

All section flops are clocked on every cycle. When the select word changes, the path picks up history that has already aged, so the output can glitch only during the cycles right after the change. Reset is asynchronous and active-low, and its release is synchronised inside the block.

Top module: `prog_delay_line`

## Requirements
- R1: While reset is held and after its release, `dout` and `cas` are low and `cas_n` is high. Reset empties every section and clears the stored select and chaining bits, so raising `hold_sel` straight after reset gives the minimum delay whatever `sel` is.
- R2: With `force_min`, `force_max` and `blank` low, a one-cycle pulse on `din` appears on `dout` exactly `MIN_LAT + S` cycles later, where S is the unsigned binary value of `sel[9:0]` (bit 0 weighs 1, bit 9 weighs 512).
- R3: A select value of zero bypasses every section, which gives a delay of exactly `MIN_LAT` cycles (2 by default).
- R4: While `hold_sel` is low, changes on `sel` and `sel_chain` act in the same cycle. A change on `sel_chain` reaches `cas` with no clock edge in between.
- R5: While `hold_sel` is high, the values stored at the last clock edge with `hold_sel` low stay in force, and changes on `sel` and `sel_chain` do not affect the delay or `cas`.
- R6: While `force_min` is high, the delay is `MIN_LAT` and `cas` is low, whatever `sel`, `sel_chain` and `force_max` are.
- R7: While `force_max` is high and `force_min` is low, the delay is `MIN_LAT + 1024` and `cas` is high.
- R8: The overrides write into the stored contents. After `force_min` is released with `hold_sel` high, the delay remains `MIN_LAT` and `cas` remains low. After `force_max` is released with `hold_sel` high, the delay is `MIN_LAT + 1023` and `cas` remains high.
- R9: While `blank` is high, `dout` is low. While it is low, the delayed signal reaches `dout`.
- R10: `cas` equals the chaining bit currently in force, and `cas_n` is always its complement.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one delay step is one period |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| din | input | 1 | Signal to be delayed |
| sel | input | 10 | Programmable delay in steps, binary weighted |
| sel_chain | input | 1 | Chaining bit, stored together with `sel` |
| hold_sel | input | 1 | Low: stored select is transparent; high: stored select is held |
| force_min | input | 1 | Force minimum delay and clear stored contents (highest priority) |
| force_max | input | 1 | Force maximum delay and fill stored contents |
| blank | input | 1 | High forces `dout` low |
| dout | output | 1 | Delayed signal |
| cas | output | 1 | Chaining output, true polarity |
| cas_n | output | 1 | Chaining output, complement |

## Verification
The bench measures the delay of isolated pulses after flushing the whole line. It covers the single-bit weights at both ends of the word and the all-ones word. A design that reversed the weights or dropped a section would report a wrong cycle count. It checks that `force_max` gives exactly one step more than all-ones, which a design without the extra section would miss by one, and that `force_min` wins over `force_max`. It also checks the hold window: a select change made while held must not move the delay. A stored value must survive an override pulse in the changed form (cleared or filled), and a design that only gated the overrides combinationally would fall back to the old stored value. Last, it checks that blanking suppresses a pulse that reaches the output.

// File: rtl/pdl_pkg.sv
package pdl_pkg;

  localparam int SEL_W_DEF   = 10;
  localparam int MIN_LAT_DEF = 2;

  typedef enum logic [1:0] {
    OVR_NONE = 2'b00,
    OVR_MIN  = 2'b01,
    OVR_MAX  = 2'b10
  } ovr_e;

  // Minimum override outranks maximum override.
  function automatic ovr_e decode_ovr(input logic fmin, input logic fmax);
    if (fmin)      return OVR_MIN;
    else if (fmax) return OVR_MAX;
    else           return OVR_NONE;
  endfunction

endpackage

// File: rtl/pdl_rst_sync.sv
module pdl_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/pdl_sel_latch.sv
module pdl_sel_latch
  import pdl_pkg::*;
#(
  parameter int SEL_W = SEL_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic             fmin,
  input  logic             fmax,
  input  logic [SEL_W-1:0] sel_in,
  input  logic             chain_in,
  output logic [SEL_W-1:0] sel_eff,
  output logic             chain_eff,
  output logic             extra_eff
);

  localparam logic [SEL_W-1:0] ALL_ONES = {SEL_W{1'b1}};

  logic [SEL_W-1:0] held_sel_q, held_sel_d;
  logic             held_chain_q, held_chain_d;
  logic             store_en;
  ovr_e             ovr;

  always_comb begin
    ovr      = decode_ovr(fmin, fmax);
    store_en = !hold || (ovr != OVR_NONE);
    held_sel_d   = held_sel_q;
    held_chain_d = held_chain_q;
    if (store_en) begin
      unique case (ovr)
        OVR_MIN: begin held_sel_d = '0;       held_chain_d = 1'b0;     end
        OVR_MAX: begin held_sel_d = ALL_ONES; held_chain_d = 1'b1;     end
        default: begin held_sel_d = sel_in;   held_chain_d = chain_in; end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_sel_q   <= '0;
      held_chain_q <= 1'b0;
    end else begin
      held_sel_q   <= held_sel_d;
      held_chain_q <= held_chain_d;
    end
  end

  always_comb begin
    unique case (ovr)
      OVR_MIN: begin sel_eff = '0;       chain_eff = 1'b0; extra_eff = 1'b0; end
      OVR_MAX: begin sel_eff = ALL_ONES; chain_eff = 1'b1; extra_eff = 1'b1; end
      default: begin
        sel_eff   = hold ? held_sel_q   : sel_in;
        chain_eff = hold ? held_chain_q : chain_in;
        extra_eff = 1'b0;
      end
    endcase
  end

  // R5
  held_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !fmin && !fmax) |=> $stable(held_sel_q) && $stable(held_chain_q));

  // R8
  min_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fmin |=> (held_sel_q == '0) && !held_chain_q);

  // R8
  max_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fmax && !fmin) |=> (held_sel_q == ALL_ONES) && held_chain_q);

endmodule

// File: rtl/pdl_stage.sv
module pdl_stage #(
  parameter int DEPTH = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic insert,
  input  logic din,
  output logic dout
);

  logic [DEPTH-1:0] sr_q, sr_d;

  generate
    if (DEPTH == 1) begin : g_single
      always_comb sr_d = din;
    end else begin : g_multi
      always_comb sr_d = {sr_q[DEPTH-2:0], din};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  assign dout = insert ? sr_q[DEPTH-1] : din;

  // R2
  shift_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> sr_q[0] == $past(din));

endmodule

// File: rtl/prog_delay_line.sv
module prog_delay_line
  import pdl_pkg::*;
#(
  parameter int SEL_W   = SEL_W_DEF,
  parameter int MIN_LAT = MIN_LAT_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             din,
  input  logic [SEL_W-1:0] sel,
  input  logic             sel_chain,
  input  logic             hold_sel,
  input  logic             force_min,
  input  logic             force_max,
  input  logic             blank,
  output logic             dout,
  output logic             cas,
  output logic             cas_n
);

  localparam int N_SECT = SEL_W + 1;

  logic             rst_n_int;
  logic [SEL_W-1:0] sel_eff;
  logic             chain_eff;
  logic             extra_eff;
  logic [N_SECT:0]  chain_sig;
  logic             line_out;

  pdl_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  pdl_sel_latch #(.SEL_W(SEL_W)) u_latch (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .hold      (hold_sel),
    .fmin      (force_min),
    .fmax      (force_max),
    .sel_in    (sel),
    .chain_in  (sel_chain),
    .sel_eff   (sel_eff),
    .chain_eff (chain_eff),
    .extra_eff (extra_eff)
  );

  assign chain_sig[0] = din;

  generate
    for (genvar k = 0; k < SEL_W; k++) begin : g_sect
      pdl_stage #(.DEPTH(1 << k)) u_sect (
        .clk    (clk),
        .rst_n  (rst_n_int),
        .insert (sel_eff[k]),
        .din    (chain_sig[k]),
        .dout   (chain_sig[k+1])
      );
    end
  endgenerate

  pdl_stage #(.DEPTH(1)) u_extra (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .insert (extra_eff),
    .din    (chain_sig[SEL_W]),
    .dout   (chain_sig[N_SECT])
  );

  generate
    if (MIN_LAT == 0) begin : g_no_pipe
      assign line_out = chain_sig[N_SECT];
    end else begin : g_pipe
      logic [MIN_LAT-1:0] pipe_q, pipe_d;
      if (MIN_LAT == 1) begin : g_p1
        always_comb pipe_d = chain_sig[N_SECT];
      end else begin : g_pn
        always_comb pipe_d = {pipe_q[MIN_LAT-2:0], chain_sig[N_SECT]};
      end
      always_ff @(posedge clk or negedge rst_n_int) begin
        if (!rst_n_int) pipe_q <= '0;
        else            pipe_q <= pipe_d;
      end
      assign line_out = pipe_q[MIN_LAT-1];
    end
  endgenerate

  assign dout  = blank ? 1'b0 : line_out;
  assign cas   = chain_eff;
  assign cas_n = ~chain_eff;

  // R9
  blank_low_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    blank |-> !dout);

  // R6
  min_cas_low_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    force_min |-> !cas && cas_n);

  // R7
  max_cas_high_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (force_max && !force_min) |-> cas && !cas_n);

endmodule

// File: tb/prog_delay_line_tb.sv
`timescale 1ns/1ps
module prog_delay_line_tb;

  localparam int SEL_W   = 10;
  localparam int MIN_LAT = 2;
  localparam int FLUSH   = 1100;
  localparam int LIMIT   = 1500;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             din;
  logic [SEL_W-1:0] sel;
  logic             sel_chain;
  logic             hold_sel;
  logic             force_min;
  logic             force_max;
  logic             blank;
  logic             dout;
  logic             cas;
  logic             cas_n;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  prog_delay_line #(.SEL_W(SEL_W), .MIN_LAT(MIN_LAT)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .din       (din),
    .sel       (sel),
    .sel_chain (sel_chain),
    .hold_sel  (hold_sel),
    .force_min (force_min),
    .force_max (force_max),
    .blank     (blank),
    .dout      (dout),
    .cas       (cas),
    .cas_n     (cas_n)
  );

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_cas(input string req, input logic exp);
    check({req, " cas"},   int'(cas),   int'(exp));
    check({req, " cas_n"}, int'(cas_n), int'(!exp));
  endtask

  task automatic flush();
    din = 1'b0;
    repeat (FLUSH) @(negedge clk);
  endtask

  // Pulse din for one cycle and count the rising edges until dout shows it.
  task automatic measure(output int d);
    flush();
    d = -1;
    @(negedge clk) din = 1'b1;
    @(negedge clk) din = 1'b0;
    for (int i = 1; i <= LIMIT; i++) begin
      if (dout) begin d = i; break; end
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; din = 1'b0; sel = 10'd77; sel_chain = 1'b0;
    hold_sel = 1'b1; force_min = 1'b0; force_max = 1'b0; blank = 1'b0;
    repeat (4) @(negedge clk);
    check("R1 dout in reset", int'(dout), 0);
    check_cas("R1 in reset", 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_cas("R1 after reset", 1'b0);
    begin
      int d;
      measure(d);
      check("R1 held cleared delay", d, MIN_LAT);
    end
  endtask

  task automatic t_weights();
    int vals[7] = '{0, 1, 2, 37, 512, 300, 1023};
    hold_sel = 1'b0;
    foreach (vals[i]) begin
      int d;
      sel = vals[i][SEL_W-1:0];
      measure(d);
      if (vals[i] == 0) check("R3 zero select", d, MIN_LAT);
      else              check($sformatf("R2 sel=%0d", vals[i]), d, MIN_LAT + vals[i]);
    end
  endtask

  task automatic t_transparent();
    hold_sel = 1'b0;
    @(negedge clk) sel_chain = 1'b1;
    #1 check_cas("R4 immediate rise", 1'b1);
    @(negedge clk) sel_chain = 1'b0;
    #1 check_cas("R4 immediate fall", 1'b0);
  endtask

  task automatic t_hold();
    int d;
    hold_sel = 1'b0; sel = 10'd3; sel_chain = 1'b0;
    repeat (2) @(negedge clk);
    hold_sel = 1'b1;
    @(negedge clk) begin sel = 10'd200; sel_chain = 1'b1; end
    #1 check_cas("R5 held chain", 1'b0);
    measure(d);
    check("R5 held delay", d, MIN_LAT + 3);
    hold_sel = 1'b0;
    #1 check_cas("R10 chain after release", 1'b1);
    measure(d);
    check("R4 new select after release", d, MIN_LAT + 200);
  endtask

  task automatic t_overrides();
    int d;
    hold_sel = 1'b0; sel = 10'd100; sel_chain = 1'b1;
    force_min = 1'b1; force_max = 1'b1;
    #1 check_cas("R6 both forces", 1'b0);
    measure(d);
    check("R6 both forces delay", d, MIN_LAT);
    force_min = 1'b0;
    #1 check_cas("R7 max force", 1'b1);
    measure(d);
    check("R7 max force delay", d, MIN_LAT + 1024);
    force_max = 1'b0;
  endtask

  task automatic t_override_store();
    int d;
    hold_sel = 1'b0; sel = 10'd3; sel_chain = 1'b1;
    repeat (2) @(negedge clk);
    hold_sel = 1'b1;
    @(negedge clk) force_min = 1'b1;
    @(negedge clk) force_min = 1'b0;
    #1 check_cas("R8 after min pulse", 1'b0);
    measure(d);
    check("R8 after min pulse delay", d, MIN_LAT);
    @(negedge clk) force_max = 1'b1;
    @(negedge clk) force_max = 1'b0;
    #1 check_cas("R8 after max pulse", 1'b1);
    measure(d);
    check("R8 after max pulse delay", d, MIN_LAT + 1023);
    hold_sel = 1'b0; sel_chain = 1'b0;
  endtask

  task automatic t_blank();
    int seen;
    int d;
    hold_sel = 1'b0; sel = 10'd5;
    flush();
    blank = 1'b1;
    seen = 0;
    @(negedge clk) din = 1'b1;
    @(negedge clk) din = 1'b0;
    for (int i = 0; i < 20; i++) begin
      if (dout) seen = 1;
      @(negedge clk);
    end
    check("R9 blanked pulse", seen, 0);
    blank = 1'b0;
    measure(d);
    check("R9 unblanked delay", d, MIN_LAT + 5);
  endtask

  initial begin
    t_reset();
    t_weights();
    t_transparent();
    t_hold();
    t_overrides();
    t_override_store();
    t_blank();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule